// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial frames on one line of a shared, multidrop bus. A frame has either eight data bits or nine. The block samples each bit at 16x oversampling and takes a majority vote of three samples at mid-bit. It then shifts the data in least significant bit first and reports a completed frame with a one-cycle done pulse. The byte and the ninth bit stay on the outputs until the next accepted frame.

When filtering is enabled, the block raises done only for frames that name this node. A node answers two addresses. The first is its individual address, which is the address register with the bits cleared in the mask register treated as don't-care. The second is a broadcast address, formed as the OR of the two registers. Frames for other nodes are dropped without any sign on the outputs. In nine-bit operation, only frames whose ninth bit is 1 count as address frames. In eight-bit operation, the stop bit plays the part of that ninth bit. A low stop bit raises a framing-error pulse instead of done.

The baud-rate generator supplies the oversampling strobe.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset, rxDone and frameErr are 0 and rxData and rxBit9 are 0.
- R2: With nineBitMode=0 and mpEnable=0, a frame with line idle 1, start bit 0, eight data bits LSB first and stop bit 1 gives exactly one rxDone pulse, and rxData holds the byte and rxBit9 reads 1 (the stop value).
- R3: With nineBitMode=1 and mpEnable=0, every frame with a valid stop bit is accepted whatever its ninth bit, and rxBit9 shows the ninth bit received after D7.
- R4: With mpEnable=1, a frame is accepted when its byte equals nodeAddr on every bit where nodeMask is 1; bits where nodeMask is 0 are not compared.
- R5: With mpEnable=1, a frame is also accepted when its byte has a 1 at every bit position where (nodeAddr | nodeMask) is 1.
- R6: With mpEnable=1 and nineBitMode=1, a frame whose ninth bit is 0 gives no rxDone and leaves rxData and rxBit9 unchanged.
- R7: With mpEnable=1, a frame that matches neither address gives no rxDone and leaves rxData unchanged.
- R8: A frame whose stop bit is sampled 0 gives one frameErr pulse and no rxDone, in either mode and with filtering on or off.
- R9: A low pulse on the idle line that is shorter than half a bit is rejected as a false start: no rxDone and no frameErr follow.
- R10: A disturbance that corrupts only one of the three mid-bit samples does not change the received bit.
- R11: rxDone and frameErr are single-cycle pulses and are never high together.
- R12: rxData changes only in the cycle in which rxDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial line, idle high |
| baudTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| nineBitMode | input | 1 | 1: nine data bits per frame, 0: eight |
| mpEnable | input | 1 | 1: address filtering on |
| nodeAddr | input | 8 | Node address register |
| nodeMask | input | 8 | Address mask, 0 marks a don't-care bit |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit (stop value in eight-bit mode) of last accepted frame |
| rxDone | output | 1 | Pulse: frame accepted |
| frameErr | output | 1 | Pulse: stop bit sampled low |

## Verification
The bench uses the default values: an 8-bit byte, 16x oversampling and a two-stage line synchronizer. It pulses baudTick once every four clocks, so one bit lasts 64 clocks. That gap makes the three vote samples four clocks apart, so a 3-clock disturbance can hit only one of them. It also places a 12-clock low pulse well short of the mid-start samples. The 8-bit width lets the vectors use exact-match masks, partial masks, broadcast-only hits and near misses on single bits.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rxState_t;

  // Strobes from the sequencer to the datapath, all single-cycle.
  typedef struct packed {
    logic idle;     // sequencer waiting for a start edge
    logic sample;   // take one vote sample of the line
    logic bitEnd;   // last tick of the current bit
    logic shift;    // voted bit is a data bit
    logic load9;    // voted bit is the ninth bit
    logic finish;   // voted bit is the stop bit, decide the frame
  } rxStrobe_t;

endpackage

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      lineSync,
  input  logic      voteBit,
  input  logic      nineBitMode,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID   = OVS / 2;

  rxState_t         state;
  logic [CNT_W-1:0] ovsCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tickLast;
  logic             inWindow;
  logic             busy;

  assign busy     = (state != ST_IDLE);
  assign tickLast = baudTick && (int'(ovsCnt) == OVS - 1);
  assign inWindow = (int'(ovsCnt) >= MID - 1) && (int'(ovsCnt) <= MID + 1);

  always_comb begin
    strobe        = '0;
    strobe.idle   = !busy;
    strobe.sample = busy && baudTick && inWindow;
    strobe.bitEnd = busy && tickLast;
    strobe.shift  = tickLast && (state == ST_DATA);
    strobe.load9  = tickLast && (state == ST_NINTH);
    strobe.finish = tickLast && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ovsCnt <= '0;
      bitIdx <= '0;
    end else if (!busy) begin
      bitIdx <= '0;
      if (baudTick && !lineSync) begin
        // the detecting tick is tick 0 of the start bit
        state  <= ST_START;
        ovsCnt <= CNT_W'(1);
      end else begin
        ovsCnt <= '0;
      end
    end else if (baudTick) begin
      ovsCnt <= tickLast ? '0 : ovsCnt + CNT_W'(1);
      if (tickLast) begin
        unique case (state)
          ST_START: state <= voteBit ? ST_IDLE : ST_DATA;
          ST_DATA: begin
            if (bitIdx == IDX_W'(DATA_W - 1)) begin
              state <= nineBitMode ? ST_NINTH : ST_STOP;
            end
            bitIdx <= bitIdx + IDX_W'(1);
          end
          ST_NINTH: state <= ST_STOP;
          ST_STOP:  state <= ST_IDLE;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdrop_rx_dpath.sv
module mdrop_rx_dpath
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic              nineBitMode,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] nodeMask,
  output logic              lineSync,
  output logic              voteBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              frameErr
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [1:0]             voteCnt;
  logic [DATA_W-1:0]      shiftQ;
  logic                   ninthQ;
  logic [DATA_W-1:0]      givenOk;
  logic [DATA_W-1:0]      bcastOk;
  logic                   addrHit;
  logic                   flagBit;
  logic                   accept;

  // line synchronizer, idle high after reset
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  // three-sample majority: two or more ones read as 1
  always_ff @(posedge clk) begin
    if (!rstN || strobe.idle || strobe.bitEnd) voteCnt <= '0;
    else if (strobe.sample && lineSync)        voteCnt <= voteCnt + 2'd1;
  end
  assign voteBit = voteCnt[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      ninthQ <= 1'b0;
    end else begin
      if (strobe.shift) shiftQ <= {voteBit, shiftQ[DATA_W-1:1]};
      if (strobe.load9) ninthQ <= voteBit;
    end
  end

  // per-bit address compare for individual and broadcast address
  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign givenOk[i] = !nodeMask[i] || (shiftQ[i] == nodeAddr[i]);
    assign bcastOk[i] = !(nodeAddr[i] || nodeMask[i]) || shiftQ[i];
  end

  assign addrHit = (&givenOk) || (&bcastOk);
  assign flagBit = nineBitMode ? ninthQ : voteBit;
  assign accept  = voteBit && (!mpEnable || (flagBit && addrHit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxDone   <= strobe.finish && accept;
      frameErr <= strobe.finish && !voteBit;
      if (strobe.finish && accept) begin
        rxData <= shiftQ;
        rxBit9 <= flagBit;
      end
    end
  end

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic              nineBitMode,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] nodeMask,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              frameErr
);

  rxStrobe_t strobe;
  logic      lineSync;
  logic      voteBit;

  mdrop_rx_ctrl #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .lineSync    (lineSync),
    .voteBit     (voteBit),
    .nineBitMode (nineBitMode),
    .strobe      (strobe)
  );

  mdrop_rx_dpath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .strobe      (strobe),
    .nineBitMode (nineBitMode),
    .mpEnable    (mpEnable),
    .nodeAddr    (nodeAddr),
    .nodeMask    (nodeMask),
    .lineSync    (lineSync),
    .voteBit     (voteBit),
    .rxData      (rxData),
    .rxBit9      (rxBit9),
    .rxDone      (rxDone),
    .frameErr    (frameErr)
  );

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              nineBitMode,
  input logic              mpEnable,
  input logic [DATA_W-1:0] nodeAddr,
  input logic [DATA_W-1:0] nodeMask,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit9,
  input logic              rxDone,
  input logic              frameErr
);

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDone && frameErr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxDone |-> $stable(rxData));

  // R6
  ninth_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && mpEnable && nineBitMode) |-> rxBit9);

  // R2
  stop_as_ninth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !nineBitMode) |-> rxBit9);

  // R4 R5 R7
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && mpEnable) |->
      ((((rxData ^ nodeAddr) & nodeMask) == '0) ||
       (((~rxData) & (nodeAddr | nodeMask)) == '0)));

endmodule

bind mdrop_uart_rx mdrop_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .nineBitMode (nineBitMode),
  .mpEnable    (mpEnable),
  .nodeAddr    (nodeAddr),
  .nodeMask    (nodeMask),
  .rxData      (rxData),
  .rxBit9      (rxBit9),
  .rxDone      (rxDone),
  .frameErr    (frameErr)
);

// File: tb/mdrop_uart_rx_tb.sv
`timescale 1ns/1ps
module mdrop_uart_rx_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int NVEC     = 19;

  typedef struct packed {
    logic [3:0] req;
    logic       nine;
    logic       mp;
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] data;
    logic       b9;
    logic       stopv;
    logic       expDone;
    logic       expErr;
  } vec_t;

  // req, nine, mp, addr, mask, data, ninth, stop, done, err
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  1'b0, 1'b0, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    '{4'd3,  1'b1, 1'b0, 8'h00, 8'h00, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0}, // R3
    '{4'd3,  1'b1, 1'b0, 8'h00, 8'h00, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0}, // R3
    '{4'd4,  1'b1, 1'b1, 8'h56, 8'hFC, 8'h57, 1'b1, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd4,  1'b1, 1'b1, 8'h56, 8'hFC, 8'h54, 1'b1, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd7,  1'b1, 1'b1, 8'h56, 8'hFC, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
    '{4'd6,  1'b1, 1'b1, 8'h56, 8'hFC, 8'h57, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd5,  1'b1, 1'b1, 8'h56, 8'hFC, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd5,  1'b1, 1'b1, 8'h56, 8'hFC, 8'hFE, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd7,  1'b1, 1'b1, 8'h56, 8'hFC, 8'h7E, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
    '{4'd4,  1'b0, 1'b1, 8'hF1, 8'hFF, 8'hF1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd7,  1'b0, 1'b1, 8'hF1, 8'hFF, 8'hF3, 1'b0, 1'b1, 1'b0, 1'b0}, // R7
    '{4'd5,  1'b0, 1'b1, 8'hF1, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd4,  1'b1, 1'b1, 8'hF3, 8'hF9, 8'hF7, 1'b1, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd7,  1'b1, 1'b1, 8'hF3, 8'hF9, 8'hF6, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
    '{4'd5,  1'b1, 1'b1, 8'hF3, 8'hF9, 8'hFB, 1'b1, 1'b1, 1'b1, 1'b0}, // R5
    '{4'd8,  1'b0, 1'b0, 8'h00, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8,  1'b1, 1'b1, 8'hF3, 8'hF9, 8'hF7, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8,  1'b0, 1'b1, 8'hF1, 8'hFF, 8'hF1, 1'b0, 1'b0, 1'b0, 1'b1}  // R8
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       nineBitMode = 1'b0;
  logic       mpEnable = 1'b0;
  logic [7:0] nodeAddr = '0;
  logic [7:0] nodeMask = '0;
  logic [7:0] rxData;
  logic       rxBit9;
  logic       rxDone;
  logic       frameErr;
  logic       baudTick;
  logic [1:0] tickDiv = '0;

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  int errCnt = 0;
  logic [7:0] expData = '0;
  logic       expB9 = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) tickDiv <= tickDiv + 2'd1;
  assign baudTick = (tickDiv == 2'd0);

  mdrop_uart_rx u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .baudTick    (baudTick),
    .nineBitMode (nineBitMode),
    .mpEnable    (mpEnable),
    .nodeAddr    (nodeAddr),
    .nodeMask    (nodeMask),
    .rxData      (rxData),
    .rxBit9      (rxBit9),
    .rxDone      (rxDone),
    .frameErr    (frameErr)
  );

  always @(negedge clk) begin
    if (rstN && rxDone)   doneCnt++;
    if (rstN && frameErr) errCnt++;
  end

  task automatic checkVal(input int req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input logic glitch);
    rxLine = v;
    if (glitch) begin
      repeat (34) @(negedge clk);
      rxLine = !v;
      repeat (3) @(negedge clk);
      rxLine = v;
      repeat (BIT_CLKS - 37) @(negedge clk);
    end else begin
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic ninth,
                           input logic useNine, input logic stopV,
                           input int glitchBit);
    driveBit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i], glitchBit == i);
    if (useNine) driveBit(ninth, 1'b0);
    driveBit(stopV, 1'b0);
    rxLine = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d0;
    int e0;
    repeat (5) @(negedge clk);
    // R1 reset state
    checkVal(1, "rxDone after reset", rxDone, 0);
    checkVal(1, "frameErr after reset", frameErr, 0);
    checkVal(1, "rxData after reset", rxData, 0);
    checkVal(1, "rxBit9 after reset", rxBit9, 0);
    rstN = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      nineBitMode = VECS[v].nine;
      mpEnable    = VECS[v].mp;
      nodeAddr    = VECS[v].addr;
      nodeMask    = VECS[v].mask;
      d0 = doneCnt;
      e0 = errCnt;
      sendFrame(VECS[v].data, VECS[v].b9, VECS[v].nine, VECS[v].stopv, -1);
      if (VECS[v].expDone) begin
        expData = VECS[v].data;
        expB9   = VECS[v].nine ? VECS[v].b9 : 1'b1;
      end
      // R11: exactly one pulse per accepted or failed frame
      checkVal(VECS[v].req, "rxDone pulses", doneCnt - d0, VECS[v].expDone);
      checkVal(VECS[v].req, "frameErr pulses", errCnt - e0, VECS[v].expErr);
      checkVal(VECS[v].req, "rxData", rxData, expData);
      checkVal(VECS[v].req, "rxBit9", rxBit9, expB9);
    end

    // R12: data held after a frame that was not accepted
    checkVal(12, "rxData held after framing error", rxData, expData);

    // R9: short low pulse on the idle line
    nineBitMode = 1'b0;
    mpEnable    = 1'b0;
    d0 = doneCnt;
    e0 = errCnt;
    rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    checkVal(9, "rxDone after false start", doneCnt - d0, 0);
    checkVal(9, "frameErr after false start", errCnt - e0, 0);
    checkVal(9, "rxData after false start", rxData, expData);

    // R10: one corrupted sample in data bits 3 and 6
    d0 = doneCnt;
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1, 3);
    checkVal(10, "rxData with glitch in bit 3", rxData, 8'h5A);
    sendFrame(8'h96, 1'b0, 1'b0, 1'b1, 6);
    checkVal(10, "rxData with glitch in bit 6", rxData, 8'h96);
    checkVal(11, "rxDone pulse count over two frames", doneCnt - d0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule